// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block moves one 8-bit frame at a time over a single bidirectional data line. It always drives the shift clock on a separate output, whether it sends or receives. A byte strobe from the CPU side starts a transmit. A receive starts on its own when receive is enabled and the receive-full flag is clear. Only one frame is in flight at a time, so the port is half duplex.

A rate-select input picks one of two bit periods. The slow rate is 12 system clocks per bit and the fast rate is 4. Each rate has a fixed gap between a data change and the falling edge of the shift clock, and a fixed length for the clock-low phase. The external device can therefore latch data on the rising shift-clock edge or at any time while the clock is low. Two sticky flags report a finished transmit and a full receive buffer. Each flag has its own clear strobe.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `sclk_o` is 1, `sd_oe_o` is 0, and both `tx_done_o` and `rx_full_o` are 0. While no frame runs, `sclk_o` stays 1.
- R2: With `rate_fast_i`=1, a bit lasts 4 clocks. Counting from the bit's first cycle (phase 0), `sclk_o` is low in phases 1 and 2 and high in phases 0 and 3. Data therefore leads the falling edge by 1 clock, and the clock stays low for 2 clocks.
- R3: With `rate_fast_i`=0, a bit lasts 12 clocks. `sclk_o` is low in phases 3 to 8 and high in all other phases. Data therefore leads the falling edge by 3 clocks, and the clock stays low for 6 clocks.
- R4: A `wr_stb_i` pulse while idle starts a transmit. The cycle after the strobe edge is phase 0 of bit 0. Bit k of `wr_byte_i` (bit 0 first) is on `sd_o` for the whole of bit period k, and `sd_oe_o` is 1 through all 8 bit periods.
- R5: `tx_done_o` becomes 1 in the cycle that follows the eighth bit period. At that point `sd_oe_o` is 0. The flag then holds until `tx_done_clr_i` is pulsed.
- R6: With `rx_en_i`=1 and `rx_full_o`=0 while idle, a receive starts. Its bit timing is the same as a transmit, and `sd_oe_o` stays 0. `sd_i` is captured at each rising edge of `sclk_o`. The first captured bit becomes bit 0 of the received byte.
- R7: `rx_full_o` becomes 1 in the cycle right after the eighth rising shift-clock edge. From that cycle on, `rd_byte_o` shows the received byte.
- R8: While `rx_full_o` is 1, no receive starts even with `rx_en_i` held at 1: `sclk_o` stays 1 and `rd_byte_o` is unchanged. After `rx_full_clr_i` is pulsed, a new receive starts.
- R9: A `wr_stb_i` pulse or a change of `rate_fast_i` during a frame has no effect on that frame's data or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_fast_i | input | 1 | 1 selects 4 clocks per bit, 0 selects 12 |
| wr_stb_i | input | 1 | Byte write strobe, starts a transmit |
| wr_byte_i | input | 8 | Byte to transmit |
| rd_byte_o | output | 8 | Last received byte |
| rx_en_i | input | 1 | Receive enable |
| tx_done_o | output | 1 | Transmit finished flag |
| rx_full_o | output | 1 | Receive buffer full flag |
| tx_done_clr_i | input | 1 | Clears the transmit finished flag |
| rx_full_clr_i | input | 1 | Clears the receive full flag |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |
| sd_oe_o | output | 1 | Output enable for the data line |
| sclk_o | output | 1 | Shift clock, idles high |

## Verification
The hardest case to reach is the stall after a full receive. `rx_en_i` must stay high across the end of a frame, so that the only thing holding the port idle is the full flag. The directed receive task keeps the enable asserted after the eighth rising edge and watches the clock line for several bit periods. It then clears the flag with the enable still high and waits for the shift clock to fall again. Mid-frame writes and rate flips are injected at a fixed cycle inside a running transmit, and the bench then compares the complete per-cycle waveform of the frame against the original byte and rate.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int FRAME_BITS = 8;
  localparam int PH_W       = 4;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  typedef logic [PH_W-1:0] phase_t;

  // clocks per bit
  function automatic phase_t bit_period(input logic fast);
    return fast ? phase_t'(4) : phase_t'(12);
  endfunction

  // clocks from data change to falling shift clock
  function automatic phase_t data_lead(input logic fast);
    return fast ? phase_t'(1) : phase_t'(3);
  endfunction

  // clocks the shift clock stays low
  function automatic phase_t low_len(input logic fast);
    return fast ? phase_t'(2) : phase_t'(6);
  endfunction
endpackage

// File: rtl/ssp_timer.sv
module ssp_timer
  import ssp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fast_i,
  output logic busy_o,
  output logic sclk_o,
  output logic last_bit_o,
  output logic ev_sample_o,
  output logic ev_bit_end_o,
  output logic ev_frame_end_o
);
  logic             rate_q;
  phase_t           ph_q;
  logic [BIT_W-1:0] bit_q;
  logic             in_low;
  phase_t           per, lead, low;

  assign per  = bit_period(rate_q);
  assign lead = data_lead(rate_q);
  assign low  = low_len(rate_q);

  assign in_low         = busy_o && (ph_q >= lead) && (ph_q < lead + low);
  assign sclk_o         = !in_low;
  assign last_bit_o     = (bit_q == BIT_W'(FRAME_BITS - 1));
  assign ev_sample_o    = busy_o && (ph_q == lead + low - phase_t'(1));
  assign ev_bit_end_o   = busy_o && (ph_q == per - phase_t'(1));
  assign ev_frame_end_o = ev_bit_end_o && last_bit_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      rate_q <= 1'b0;
      ph_q   <= '0;
      bit_q  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        rate_q <= fast_i;
        ph_q   <= '0;
        bit_q  <= '0;
      end
    end else if (ev_bit_end_o) begin
      ph_q <= '0;
      if (last_bit_o) busy_o <= 1'b0;
      else            bit_q  <= bit_q + BIT_W'(1);
    end else begin
      ph_q <= ph_q + phase_t'(1);
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sclk_o);
  assert_sample_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sample_o |-> !sclk_o);
  assert_rate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(rate_q));
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
  import ssp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] load_byte_i,
  input  logic                  shift_i,
  input  logic                  sample_i,
  input  logic                  last_i,
  input  logic                  sd_i,
  output logic                  tx_bit_o,
  output logic                  rx_done_o,
  output logic [FRAME_BITS-1:0] rx_byte_o
);
  logic [FRAME_BITS-1:0] tx_q, rx_q, rx_next;

  assign rx_next   = {sd_i, rx_q[FRAME_BITS-1:1]};
  assign rx_done_o = sample_i && last_i;
  assign tx_bit_o  = tx_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q      <= '1;
      rx_q      <= '0;
      rx_byte_o <= '0;
    end else begin
      if (load_i)       tx_q      <= load_byte_i;
      else if (shift_i) tx_q      <= {1'b1, tx_q[FRAME_BITS-1:1]};
      if (sample_i)     rx_q      <= rx_next;
      if (rx_done_o)    rx_byte_o <= rx_next;
    end
  end
endmodule

// File: rtl/ssp_flag.sv
module ssp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rate_fast_i,
  input  logic       wr_stb_i,
  input  logic [7:0] wr_byte_i,
  output logic [7:0] rd_byte_o,
  input  logic       rx_en_i,
  output logic       tx_done_o,
  output logic       rx_full_o,
  input  logic       tx_done_clr_i,
  input  logic       rx_full_clr_i,
  output logic       sd_o,
  input  logic       sd_i,
  output logic       sd_oe_o,
  output logic       sclk_o
);
  logic busy, last_bit, ev_sample, ev_bit_end, ev_frame_end;
  logic tx_start, rx_start, is_tx_q, tx_bit, rx_done, tx_set;

  assign tx_start = !busy && wr_stb_i;
  assign rx_start = !busy && !wr_stb_i && rx_en_i && !rx_full_o;
  assign tx_set   = ev_frame_end && is_tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     is_tx_q <= 1'b0;
    else if (tx_start || rx_start)  is_tx_q <= tx_start;
  end

  ssp_timer u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(tx_start || rx_start), .fast_i(rate_fast_i),
    .busy_o(busy), .sclk_o(sclk_o), .last_bit_o(last_bit), .ev_sample_o(ev_sample),
    .ev_bit_end_o(ev_bit_end), .ev_frame_end_o(ev_frame_end)
  );

  ssp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(tx_start), .load_byte_i(wr_byte_i),
    .shift_i(ev_bit_end && is_tx_q), .sample_i(ev_sample && !is_tx_q),
    .last_i(last_bit), .sd_i(sd_i), .tx_bit_o(tx_bit), .rx_done_o(rx_done),
    .rx_byte_o(rd_byte_o)
  );

  ssp_flag u_tx_flag (.clk(clk), .rst_n(rst_n), .set_i(tx_set),
                      .clr_i(tx_done_clr_i), .flag_o(tx_done_o));
  ssp_flag u_rx_flag (.clk(clk), .rst_n(rst_n), .set_i(rx_done),
                      .clr_i(rx_full_clr_i), .flag_o(rx_full_o));

  assign sd_oe_o = busy && is_tx_q;
  assign sd_o    = sd_oe_o ? tx_bit : 1'b1;

  assert_tx_done_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done_o) |-> $past(ev_frame_end && is_tx_q));
  assert_rx_full_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full_o) |-> $past(ev_sample && last_bit));
  assert_no_rx_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rx_full_o && !wr_stb_i) |=> !busy);
  assert_oe_only_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_tx_q) |-> !sd_oe_o);
endmodule

// File: tb/sync_shift_port_bench.sv
module sync_shift_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rate_fast_i = 1'b0, wr_stb_i = 1'b0, rx_en_i = 1'b0, sd_i = 1'b1;
  logic tx_done_clr_i = 1'b0, rx_full_clr_i = 1'b0;
  logic [7:0] wr_byte_i = 8'h00;
  logic [7:0] rd_byte_o;
  logic tx_done_o, rx_full_o, sd_o, sd_oe_o, sclk_o;
  int total = 0, bad = 0, cycles = 0;

  always #10 clk = ~clk;

  sync_shift_port u_sync_shift_port (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int per_of(input bit f);  return f ? 4 : 12; endfunction
  function automatic int lead_of(input bit f); return f ? 1 : 3;  endfunction
  function automatic int low_of(input bit f);  return f ? 2 : 6;  endfunction
  function automatic bit clk_exp(input bit f, input int ph);
    return !(ph >= lead_of(f) && ph < lead_of(f) + low_of(f));
  endfunction

  task automatic run_tx(input logic [7:0] b, input bit f, input bit disturb);
    int p;
    p = per_of(f);
    rate_fast_i = f;
    @(negedge clk); wr_stb_i = 1'b1; wr_byte_i = b;
    @(negedge clk); wr_stb_i = 1'b0;
    for (int i = 0; i < 8 * p; i++) begin
      check(sclk_o == clk_exp(f, i % p), f ? "R2 sclk" : "R3 sclk", sclk_o, clk_exp(f, i % p));
      check(sd_o == b[i / p], disturb ? "R9 sd_o" : "R4 sd_o", sd_o, b[i / p]);
      check(sd_oe_o == 1'b1, "R4 oe", sd_oe_o, 1);
      if (i == 8 * p - 1) check(tx_done_o == 1'b0, "R5 early", tx_done_o, 0);
      if (disturb && i == 5) begin wr_stb_i = 1'b1; wr_byte_i = ~b; rate_fast_i = !f; end
      if (disturb && i == 6) begin wr_stb_i = 1'b0; rate_fast_i = f; end
      @(negedge clk);
    end
    check(tx_done_o == 1'b1, "R5 set", tx_done_o, 1);
    check(sd_oe_o == 1'b0, "R5 oe off", sd_oe_o, 0);
    repeat (3) @(negedge clk);
    check(tx_done_o == 1'b1, "R5 hold", tx_done_o, 1);
    tx_done_clr_i = 1'b1; @(negedge clk); tx_done_clr_i = 1'b0;
    check(tx_done_o == 1'b0, "R5 clear", tx_done_o, 0);
  endtask

  task automatic run_rx(input logic [7:0] b, input bit f);
    int p, hit;
    p = per_of(f); hit = 7 * p + lead_of(f) + low_of(f);
    rate_fast_i = f;
    @(negedge clk); rx_en_i = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8 * p; i++) begin
      if (i % p == lead_of(f)) sd_i = b[i / p];
      check(sclk_o == clk_exp(f, i % p), "R6 sclk", sclk_o, clk_exp(f, i % p));
      check(sd_oe_o == 1'b0, "R6 oe", sd_oe_o, 0);
      if (i == hit - 1) check(rx_full_o == 1'b0, "R7 early", rx_full_o, 0);
      if (i == hit) begin
        check(rx_full_o == 1'b1, "R7 set", rx_full_o, 1);
        check(rd_byte_o == b, "R7 byte", rd_byte_o, b);
      end
      @(negedge clk);
    end
    sd_i = ~sd_i;
    for (int i = 0; i < 3 * p; i++) begin
      check(sclk_o == 1'b1, "R8 stalled sclk", sclk_o, 1);
      @(negedge clk);
    end
    check(rd_byte_o == b, "R8 byte kept", rd_byte_o, b);
  endtask

  task automatic rx_restart(input bit f);
    int seen;
    seen = 0;
    rx_full_clr_i = 1'b1; @(negedge clk); rx_full_clr_i = 1'b0;
    for (int i = 0; i < 2 * per_of(f); i++) begin
      if (!sclk_o) seen = 1;
      @(negedge clk);
    end
    check(seen == 1, "R8 restart", seen, 1);
    rx_en_i = 1'b0;
    repeat (10 * per_of(f)) @(negedge clk);
    rx_full_clr_i = 1'b1; @(negedge clk); rx_full_clr_i = 1'b0;
    @(negedge clk);
    check(rx_full_o == 1'b0, "R8 cleared", rx_full_o, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sclk_o == 1'b1, "R1 sclk", sclk_o, 1);
    check(sd_oe_o == 1'b0, "R1 oe", sd_oe_o, 0);
    check(tx_done_o == 1'b0 && rx_full_o == 1'b0, "R1 flags", {tx_done_o, rx_full_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sclk_o == 1'b1, "R1 idle sclk", sclk_o, 1);
    run_tx(8'hA5, 1'b1, 1'b0);
    run_tx(8'h3C, 1'b0, 1'b0);
    run_tx(8'h96, 1'b1, 1'b1);
    run_tx(8'h71, 1'b0, 1'b1);
    run_rx(8'hC3, 1'b1);
    rx_restart(1'b1);
    run_rx(8'h5E, 1'b0);
    rx_restart(1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule